// File: doc/BRIEF.md
# Variable-Page Unified TLB with Fault Classifier

This block translates a 32-bit virtual address into a physical address through a fully associative table of 64 entries. Each entry holds a page of 1 KB, 4 KB, 64 KB or 1 MB. The block first sorts every access into one of four region classes:

- **RG_MAPPED**: the table is consulted.
- **RG_PHYS_MASK**: the top three address bits are cleared.
- **RG_PHYS_FLAT**: the address passes through unchanged.
- **RG_DENIED**: a user-mode address error.

A table lookup can end in one of six verdicts:

- **VD_NONE**: the access succeeds.
- **VD_ADDR_ERR**: a user-mode access to a reserved region.
- **VD_MULTI**: more than one entry matches.
- **VD_MISS**: no entry matches.
- **VD_PROT**: the access breaks the entry's permissions.
- **VD_FIRST_WR**: a permitted store to a clean page.

Each verdict comes with its exception code. The translation result is combinational from the registered table contents. On a fault the physical address output carries no meaning.

A 6-bit replacement counter picks the slot that the entry write port fills. The counter has two transitions:

- **CTR_ADVANCE**: the counter steps to the next index.
- **CTR_WRAP**: the counter returns to zero.

It steps on every access strobe whose class is RG_MAPPED. It wraps when the next value passes a nonzero boundary input, or when it passes the last table index. A write does not move the counter.

Top module: `vtlb_xlate`

## Requirements
- R1: Addresses 0x80000000–0xBFFFFFFF are not translated. A privileged access there succeeds with a physical address equal to the virtual address with bits 31:29 cleared.
- R2: Addresses at or above 0xE0000000 are not translated. They pass through unchanged for privileged accesses. In user mode they pass through only inside 0xE0000000–0xE3FFFFFF.
- R3: A user-mode access to any other untranslated address gives fault kind 1 (address error). The exception code is 0x0E0 for a fetch or load and 0x100 for a store.
- R4: With translation disabled, the addresses below 0x80000000 and those in 0xC0000000–0xDFFFFFFF succeed with bits 31:29 cleared. No permission check is made, and the counter does not step.
- R5: An entry matches only when all of the following hold: it is valid; it is shared, or its 8-bit ASID equals the current ASID, or ASID checking is off; and the address lies inside its page.
- R6: ASID checking is off only when single-virtual mode is set and the access is privileged.
- R7: The size code selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. The page base and the physical base are both aligned down to that size. The physical address is the aligned physical base plus the in-page offset.
- R8: Two or more matching entries give fault kind 2 and code 0x140. This check comes before all others.
- R9: The access type is encoded as 0 fetch, 1 load, 2 store (3 acts as a load). No match gives fault kind 3, with code 0x040 for a fetch or load and 0x060 for a store.
- R10: Protection bit 1 grants user access and protection bit 0 grants writes. A user access to an entry with bit 1 clear gives fault kind 4, with code 0x0A0 for a fetch or load and 0x0C0 for a store. A store to an entry with bit 0 clear also gives kind 4 with code 0x0C0.
- R11: A store that passes the protection checks but hits an entry whose dirty bit is clear gives fault kind 5 and code 0x080.
- R12: The replacement counter resets to 0 and steps by one on each RG_MAPPED access strobe. The step becomes a wrap to 0 when the new value exceeds a nonzero boundary input, or exceeds 63.
- R13: A write stores the new entry in the slot indexed by the replacement counter. It replaces whatever that slot held. All entries are invalid after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Access strobe; steps the counter for RG_MAPPED accesses |
| lk_vaddr | input | 32 | Virtual address |
| lk_kind | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| lk_priv | input | 1 | Privileged mode |
| lk_asid | input | 8 | Current address-space identifier |
| single_virt | input | 1 | Single-virtual mode flag |
| xlate_en | input | 1 | Translation enable |
| repl_bound | input | 6 | Counter boundary; 0 means none |
| wr_en | input | 1 | Entry write strobe |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn | input | 19 | Physical page number (address bits 28:10) |
| wr_asid | input | 8 | Entry ASID |
| wr_size | input | 2 | Page size code |
| wr_prot | input | 2 | Protection bits: 1 user access, 0 write |
| wr_dirty | input | 1 | Dirty bit |
| wr_shared | input | 1 | Shared bit |
| wr_valid | input | 1 | Valid bit |
| xl_paddr | output | 32 | Physical address, meaningful when xl_hit is set |
| xl_hit | output | 1 | Access resolved without a fault |
| fault_kind | output | 3 | Verdict: 0 none, 1 address error, 2 multi-hit, 3 miss, 4 protection, 5 first write |
| exc_code | output | 12 | Exception code, 0 when no fault |
| repl_idx | output | 6 | Replacement counter value |

## Verification
The table is filled with entries of all four sizes. Accesses land just inside and just outside each page, which separates correct size masking from correct offset merging. Matching is exercised in three ways:

- ASID mismatches, shared entries and single-virtual privileged accesses separate the three match conditions.
- An invalid copy of a live entry shows that the valid bit gates matching.
- A small page inside a large one separates multi-hit from single-hit selection.

Fetch, load and store are each tried against entries whose permissions and dirty bits differ, so every fault kind has its own access. Every untranslated window is probed in both privilege modes. A run of accesses with and without a boundary separates the two wrap rules and shows which accesses step the counter.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VA_W   = 32;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int CODE_W = 12;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        RG_MAPPED    = 2'd0,
        RG_PHYS_MASK = 2'd1,
        RG_PHYS_FLAT = 2'd2,
        RG_DENIED    = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        VD_NONE     = 3'd0,
        VD_ADDR_ERR = 3'd1,
        VD_MULTI    = 3'd2,
        VD_MISS     = 3'd3,
        VD_PROT     = 3'd4,
        VD_FIRST_WR = 3'd5
    } verdict_e;

    localparam logic [CODE_W-1:0] EXC_MISS_RD   = 12'h040;
    localparam logic [CODE_W-1:0] EXC_MISS_WR   = 12'h060;
    localparam logic [CODE_W-1:0] EXC_FIRST_WR  = 12'h080;
    localparam logic [CODE_W-1:0] EXC_PROT_RD   = 12'h0A0;
    localparam logic [CODE_W-1:0] EXC_PROT_WR   = 12'h0C0;
    localparam logic [CODE_W-1:0] EXC_ADDR_RD   = 12'h0E0;
    localparam logic [CODE_W-1:0] EXC_ADDR_WR   = 12'h100;
    localparam logic [CODE_W-1:0] EXC_MULTI     = 12'h140;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
        logic [1:0]        size;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    // Page-number bits that take part in the compare for a given size.
    function automatic logic [VPN_W-1:0] page_keep_mask(input logic [1:0] size);
        logic [VPN_W-1:0] m;
        unique case (size)
            2'd0: m = {VPN_W{1'b1}};
            2'd1: m = {{(VPN_W-2){1'b1}}, 2'b00};
            2'd2: m = {{(VPN_W-6){1'b1}}, 6'b000000};
            2'd3: m = {{(VPN_W-10){1'b1}}, 10'b0000000000};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vtlb_entry_store.sv
module vtlb_entry_store
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_ent_t                  wr_ent,
    output tlb_ent_t [ENTRIES-1:0]    tbl_q
);

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                tbl_q[gi] <= wr_ent;
            end
        end
    end

    // R13: the slot picked by the counter holds the written entry afterwards.
    p_slot_written_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)] == $past(wr_ent)));

endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  tlb_ent_t [ENTRIES-1:0]  tbl,
    input  logic [VPN_W-1:0]        va_vpn,
    input  logic [ASID_W-1:0]       cur_asid,
    input  logic                    asid_chk,
    output logic                    hit_any,
    output logic                    hit_multi,
    output tlb_ent_t                sel
);

    logic [ENTRIES-1:0] mvec;
    logic [CNT_W-1:0]   hit_cnt;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        logic [VPN_W-1:0] keep;
        logic             asid_ok;
        logic             page_ok;
        always_comb begin
            keep    = page_keep_mask(tbl[gi].size);
            asid_ok = tbl[gi].shared || !asid_chk || (tbl[gi].asid == cur_asid);
            page_ok = ((tbl[gi].vpn ^ va_vpn) & keep) == '0;
            mvec[gi] = tbl[gi].valid && asid_ok && page_ok;
        end
    end

    always_comb begin
        hit_cnt = '0;
        sel     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_cnt = hit_cnt + CNT_W'(mvec[i]);
            if (mvec[i]) begin
                sel = tlb_ent_t'(sel | tbl[i]);
            end
        end
        hit_any   = (hit_cnt != '0);
        hit_multi = (hit_cnt > CNT_W'(1));
    end

endmodule

// File: rtl/vtlb_repl_ctr.sv
module vtlb_repl_ctr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] ctr_q
);

    typedef enum logic [1:0] {
        CTR_HOLD    = 2'd0,
        CTR_ADVANCE = 2'd1,
        CTR_WRAP    = 2'd2
    } ctr_step_e;

    localparam logic [IDX_W:0] LAST = (IDX_W+1)'(ENTRIES - 1);

    logic [IDX_W:0]   stepped;
    ctr_step_e        step;
    logic [IDX_W-1:0] ctr_d;

    always_comb begin
        stepped = {1'b0, ctr_q} + (IDX_W+1)'(1);
        if (!adv) begin
            step = CTR_HOLD;
        end else if (((bound != '0) && (stepped > {1'b0, bound})) || (stepped > LAST)) begin
            step = CTR_WRAP;
        end else begin
            step = CTR_ADVANCE;
        end
        unique case (step)
            CTR_HOLD:    ctr_d = ctr_q;
            CTR_ADVANCE: ctr_d = stepped[IDX_W-1:0];
            CTR_WRAP:    ctr_d = '0;
            default:     ctr_d = ctr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // R12: an access either steps by one or returns to zero.
    p_ctr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((ctr_q == $past(ctr_q) + IDX_W'(1)) || (ctr_q == '0)));

    // R12: without an access the counter keeps its value.
    p_ctr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ctr_q));

    // R12: with a boundary in force and a start at or below it, the counter never passes it.
    p_ctr_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (bound != '0) && (ctr_q <= bound)) |=> (ctr_q <= $past(bound)));

endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic              lk_priv,
    input  logic [7:0]        lk_asid,
    input  logic              single_virt,
    input  logic              xlate_en,
    input  logic [IDX_W-1:0]  repl_bound,
    input  logic              wr_en,
    input  logic [21:0]       wr_vpn,
    input  logic [18:0]       wr_ppn,
    input  logic [7:0]        wr_asid,
    input  logic [1:0]        wr_size,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    input  logic              wr_shared,
    input  logic              wr_valid,
    output logic [31:0]       xl_paddr,
    output logic              xl_hit,
    output logic [2:0]        fault_kind,
    output logic [11:0]       exc_code,
    output logic [IDX_W-1:0]  repl_idx
);

    tlb_ent_t [ENTRIES-1:0] tbl;
    tlb_ent_t               wr_ent;
    tlb_ent_t               sel;
    logic                   hit_any;
    logic                   hit_multi;
    logic                   asid_chk;
    logic                   is_store;
    logic                   in_mask_win;
    logic                   in_flat_win;
    logic                   in_user_win;
    region_e                region;
    verdict_e               verdict;
    logic [VPN_W-1:0]       keep;
    logic [VPN_W-1:0]       pfn_merged;

    always_comb begin
        wr_ent.valid  = wr_valid;
        wr_ent.shared = wr_shared;
        wr_ent.dirty  = wr_dirty;
        wr_ent.prot   = wr_prot;
        wr_ent.size   = wr_size;
        wr_ent.asid   = wr_asid;
        wr_ent.vpn    = wr_vpn;
        wr_ent.ppn    = wr_ppn;
    end

    vtlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (repl_idx),
        .wr_ent (wr_ent),
        .tbl_q  (tbl)
    );

    assign asid_chk = !(single_virt && lk_priv);

    vtlb_match #(.ENTRIES(ENTRIES)) u_match (
        .tbl       (tbl),
        .va_vpn    (lk_vaddr[31:10]),
        .cur_asid  (lk_asid),
        .asid_chk  (asid_chk),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .sel       (sel)
    );

    vtlb_repl_ctr #(.ENTRIES(ENTRIES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (lk_valid && (region == RG_MAPPED)),
        .bound (repl_bound),
        .ctr_q (repl_idx)
    );

    // Region classification.
    always_comb begin
        in_mask_win = (lk_vaddr[31:30] == 2'b10);
        in_flat_win = (lk_vaddr[31:29] == 3'b111);
        in_user_win = (lk_vaddr[31:26] == 6'b111000);
        if (in_mask_win || in_flat_win) begin
            if (!lk_priv && !in_user_win) begin
                region = RG_DENIED;
            end else if (in_mask_win) begin
                region = RG_PHYS_MASK;
            end else begin
                region = RG_PHYS_FLAT;
            end
        end else if (!xlate_en) begin
            region = RG_PHYS_MASK;
        end else begin
            region = RG_MAPPED;
        end
    end

    // Verdict and result.
    always_comb begin
        is_store   = (access_e'(lk_kind) == ACC_STORE);
        keep       = page_keep_mask(sel.size);
        pfn_merged = ({3'b000, sel.ppn} & keep) | (lk_vaddr[31:10] & ~keep);
        verdict    = VD_NONE;
        xl_paddr   = lk_vaddr;
        unique case (region)
            RG_PHYS_FLAT: begin
                xl_paddr = lk_vaddr;
            end
            RG_PHYS_MASK: begin
                xl_paddr = {3'b000, lk_vaddr[28:0]};
            end
            RG_DENIED: begin
                verdict = VD_ADDR_ERR;
            end
            RG_MAPPED: begin
                xl_paddr = {pfn_merged, lk_vaddr[9:0]};
                if (hit_multi) begin
                    verdict = VD_MULTI;
                end else if (!hit_any) begin
                    verdict = VD_MISS;
                end else if (!lk_priv && !sel.prot[1]) begin
                    verdict = VD_PROT;
                end else if (is_store && !sel.prot[0]) begin
                    verdict = VD_PROT;
                end else if (is_store && !sel.dirty) begin
                    verdict = VD_FIRST_WR;
                end
            end
        endcase
    end

    always_comb begin
        xl_hit     = (verdict == VD_NONE);
        fault_kind = verdict;
        unique case (verdict)
            VD_NONE:     exc_code = '0;
            VD_ADDR_ERR: exc_code = is_store ? EXC_ADDR_WR : EXC_ADDR_RD;
            VD_MULTI:    exc_code = EXC_MULTI;
            VD_MISS:     exc_code = is_store ? EXC_MISS_WR : EXC_MISS_RD;
            VD_PROT:     exc_code = is_store ? EXC_PROT_WR : EXC_PROT_RD;
            VD_FIRST_WR: exc_code = EXC_FIRST_WR;
            default:     exc_code = '0;
        endcase
    end

    // R8: multiple matches from the match array always surface as the multi-hit code.
    p_multi_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((region == RG_MAPPED) && hit_multi) |-> (!xl_hit && (exc_code == EXC_MULTI)));

    // R3: a user access to the masked window never succeeds.
    p_user_mask_denied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_priv && (lk_vaddr[31:30] == 2'b10))
            |-> (!xl_hit && ((exc_code == EXC_ADDR_RD) || (exc_code == EXC_ADDR_WR))));

    // R11: a successful translated store used a writable, dirty entry.
    p_store_dirty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((region == RG_MAPPED) && is_store && xl_hit) |-> (sel.dirty && sel.prot[0]));

    // R4: with translation off, low addresses come out with bits 31:29 cleared.
    p_xlate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlate_en && !lk_vaddr[31]) |-> (xl_hit && (xl_paddr[31:29] == 3'b000)
                                          && (xl_paddr[28:0] == lk_vaddr[28:0])));

endmodule

// File: tb/vtlb_xlate_bench.sv
module vtlb_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_priv = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic        single_virt = 1'b0;
    logic        xlate_en = 1'b0;
    logic [5:0]  repl_bound = '0;
    logic        wr_en = 1'b0;
    logic [21:0] wr_vpn = '0;
    logic [18:0] wr_ppn = '0;
    logic [7:0]  wr_asid = '0;
    logic [1:0]  wr_size = '0;
    logic [1:0]  wr_prot = '0;
    logic        wr_dirty = 1'b0;
    logic        wr_shared = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] xl_paddr;
    logic        xl_hit;
    logic [2:0]  fault_kind;
    logic [11:0] exc_code;
    logic [5:0]  repl_idx;

    always #5 clk = ~clk;

    vtlb_xlate u_vtlb_xlate (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_priv(lk_priv), .lk_asid(lk_asid),
        .single_virt(single_virt), .xlate_en(xlate_en), .repl_bound(repl_bound),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid),
        .wr_size(wr_size), .wr_prot(wr_prot), .wr_dirty(wr_dirty),
        .wr_shared(wr_shared), .wr_valid(wr_valid), .xl_paddr(xl_paddr),
        .xl_hit(xl_hit), .fault_kind(fault_kind), .exc_code(exc_code),
        .repl_idx(repl_idx)
    );

    typedef struct {
        logic        ok;
        logic [2:0]  kind;
        logic [11:0] code;
        logic [31:0] pa;
        logic [5:0]  ridx;
        string       tag;
    } exp_t;

    typedef struct {
        logic        valid;
        logic        shared;
        logic        dirty;
        logic [1:0]  prot;
        logic [1:0]  size;
        logic [7:0]  asid;
        logic [31:0] vbase;
        logic [31:0] pbase;
    } mdl_ent_t;

    exp_t     scb_q[$];
    mdl_ent_t mdl[64];
    int       mctr = 0;
    int       n_checks = 0;
    int       n_errors = 0;
    bit       finished = 0;

    function automatic logic [31:0] page_bytes(input logic [1:0] s);
        case (s)
            2'd0: return 32'd1024;
            2'd1: return 32'd4096;
            2'd2: return 32'd65536;
            default: return 32'd1048576;
        endcase
    endfunction

    // Reference result, written from the requirement list.
    function automatic exp_t predict(input logic [31:0] va, input logic [1:0] k,
                                     input logic pr, input logic [7:0] asid,
                                     input logic sv, input logic xe, output bit adv);
        exp_t r;
        bit   st;
        int   n;
        int   m;
        logic [31:0] sz;
        logic [31:0] base;
        r.ok = 1'b1; r.kind = 3'd0; r.code = 12'h000; r.pa = 32'h0;
        r.ridx = 6'(mctr); r.tag = "";
        st  = (k == 2'd2);
        adv = 1'b0;
        if (va >= 32'h8000_0000 && va < 32'hC000_0000 || va >= 32'hE000_0000) begin
            if (!pr && !(va >= 32'hE000_0000 && va < 32'hE400_0000)) begin
                r.ok = 1'b0; r.kind = 3'd1; r.code = st ? 12'h100 : 12'h0E0;
            end else begin
                r.pa = (va >= 32'hE000_0000) ? va : (va & 32'h1FFF_FFFF);
            end
        end else if (!xe) begin
            r.pa = va & 32'h1FFF_FFFF;
        end else begin
            adv = 1'b1;
            n = 0; m = 0;
            for (int i = 0; i < 64; i++) begin
                sz   = page_bytes(mdl[i].size);
                base = mdl[i].vbase & ~(sz - 1);
                if (mdl[i].valid && (mdl[i].shared || (sv && pr) || mdl[i].asid == asid)
                    && va >= base && va <= base + sz - 1) begin
                    n++; m = i;
                end
            end
            if (n > 1) begin
                r.ok = 1'b0; r.kind = 3'd2; r.code = 12'h140;
            end else if (n == 0) begin
                r.ok = 1'b0; r.kind = 3'd3; r.code = st ? 12'h060 : 12'h040;
            end else if (!pr && !mdl[m].prot[1]) begin
                r.ok = 1'b0; r.kind = 3'd4; r.code = st ? 12'h0C0 : 12'h0A0;
            end else if (st && !mdl[m].prot[0]) begin
                r.ok = 1'b0; r.kind = 3'd4; r.code = 12'h0C0;
            end else if (st && !mdl[m].dirty) begin
                r.ok = 1'b0; r.kind = 3'd5; r.code = 12'h080;
            end else begin
                sz   = page_bytes(mdl[m].size);
                r.pa = (mdl[m].pbase & ~(sz - 1)) | (va & (sz - 1));
            end
        end
        return r;
    endfunction

    task automatic step_model(input bit adv);
        if (adv) begin
            if ((repl_bound != 0 && mctr + 1 > repl_bound) || mctr + 1 > 63) mctr = 0;
            else mctr = mctr + 1;
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] k, input logic pr,
                        input logic [7:0] asid, input logic sv, input logic xe,
                        input string tag);
        exp_t e;
        bit   adv;
        @(posedge clk); #2;
        wr_en = 1'b0;
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = k; lk_priv = pr;
        lk_asid = asid; single_virt = sv; xlate_en = xe;
        e = predict(va, k, pr, asid, sv, xe, adv);
        e.tag = tag;
        scb_q.push_back(e);
        step_model(adv);
    endtask

    task automatic put(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] s,
                       input logic [7:0] asid, input logic [1:0] p, input logic d,
                       input logic sh, input logic v);
        @(posedge clk); #2;
        lk_valid = 1'b0;
        wr_en = 1'b1; wr_vpn = va[31:10]; wr_ppn = pa[28:10]; wr_size = s;
        wr_asid = asid; wr_prot = p; wr_dirty = d; wr_shared = sh; wr_valid = v;
        mdl[mctr] = '{valid: v, shared: sh, dirty: d, prot: p, size: s, asid: asid,
                      vbase: {va[31:10], 10'b0}, pbase: {3'b000, pa[28:10], 10'b0}};
    endtask

    task automatic idle();
        @(posedge clk); #2;
        lk_valid = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: compares the oldest expectation at the falling edge.
    always @(negedge clk) begin
        if (rst_n && scb_q.size() > 0) begin
            exp_t e;
            bit   bad;
            e = scb_q.pop_front();
            bad = (xl_hit !== e.ok) || (fault_kind !== e.kind) || (repl_idx !== e.ridx)
                  || (!e.ok && exc_code !== e.code) || (e.ok && xl_paddr !== e.pa);
            n_checks++;
            if (bad) begin
                n_errors++;
                $display("FAIL %s: got hit=%0b kind=%0d code=%03h pa=%08h idx=%0d, expected hit=%0b kind=%0d code=%03h pa=%08h idx=%0d",
                         e.tag, xl_hit, fault_kind, exc_code, xl_paddr, repl_idx,
                         e.ok, e.kind, e.code, e.pa, e.ridx);
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '{default: '0};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // Reset state: empty table, counter at zero (R13, R12, R9)
        look(32'h0001_2ABC, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R13 reset miss");
        put(32'h0001_2000, 32'h0500_0000, 2'd1, 8'd5, 2'b11, 1'b1, 1'b0, 1'b1);
        look(32'h0001_2ABC, 2'd1, 1'b0, 8'd5, 1'b0, 1'b1, "R7 4K hit");
        put(32'h0030_0000, 32'h0120_0000, 2'd3, 8'd9, 2'b01, 1'b0, 1'b1, 1'b1);
        look(32'h0034_5678, 2'd1, 1'b0, 8'd5, 1'b0, 1'b1, "R10 user read prot");
        look(32'h0034_5678, 2'd1, 1'b1, 8'd7, 1'b0, 1'b1, "R5 shared 1M");
        look(32'h0034_5678, 2'd2, 1'b1, 8'd7, 1'b0, 1'b1, "R11 clean page store");
        put(32'h0050_0400, 32'h00A0_0C00, 2'd0, 8'd5, 2'b10, 1'b1, 1'b0, 1'b1);
        look(32'h0050_0410, 2'd2, 1'b0, 8'd5, 1'b0, 1'b1, "R10 store read-only");
        look(32'h0050_0410, 2'd0, 1'b0, 8'd5, 1'b0, 1'b1, "R7 1K fetch");
        look(32'h0050_0810, 2'd1, 1'b0, 8'd5, 1'b0, 1'b1, "R9 miss past 1K");
        put(32'h0070_0000, 32'h0333_0000, 2'd2, 8'd5, 2'b11, 1'b1, 1'b0, 1'b1);
        look(32'h0070_FFFC, 2'd2, 1'b0, 8'd5, 1'b0, 1'b1, "R7 64K top store");
        look(32'h0071_0000, 2'd2, 1'b0, 8'd5, 1'b0, 1'b1, "R9 store miss");
        look(32'h0001_2ABC, 2'd1, 1'b0, 8'd6, 1'b0, 1'b1, "R5 asid mismatch");
        look(32'h0001_2ABC, 2'd1, 1'b1, 8'd6, 1'b1, 1'b1, "R6 single-virtual priv");
        look(32'h0001_2ABC, 2'd1, 1'b0, 8'd6, 1'b1, 1'b1, "R6 single-virtual user");
        put(32'h0090_0000, 32'h0AB0_0000, 2'd3, 8'd5, 2'b11, 1'b1, 1'b0, 1'b1);
        look(32'h0098_0000, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R7 1M hit");
        put(32'h0090_5000, 32'h0000_1000, 2'd1, 8'd5, 2'b11, 1'b1, 1'b0, 1'b1);
        look(32'h0090_5123, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R8 multi load");
        look(32'h0090_5123, 2'd2, 1'b0, 8'd5, 1'b0, 1'b1, "R8 multi store");
        look(32'h0098_0000, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R8 single outside 4K");
        put(32'h0001_2000, 32'h0700_0000, 2'd1, 8'd5, 2'b11, 1'b1, 1'b0, 1'b0);
        look(32'h0001_2ABC, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R5 invalid ignored");
        // Untranslated regions
        look(32'hA123_4567, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R1 priv masked");
        look(32'h8ABC_DEF0, 2'd0, 1'b1, 8'd5, 1'b0, 1'b1, "R1 priv fetch");
        look(32'h8123_4567, 2'd1, 1'b0, 8'd5, 1'b0, 1'b1, "R3 user load");
        look(32'hA000_0000, 2'd2, 1'b0, 8'd5, 1'b0, 1'b1, "R3 user store");
        look(32'hF000_0000, 2'd0, 1'b0, 8'd5, 1'b0, 1'b1, "R3 user fetch high");
        look(32'hE3FF_FFFC, 2'd2, 1'b0, 8'd5, 1'b0, 1'b1, "R2 user window");
        look(32'hE400_0000, 2'd1, 1'b0, 8'd5, 1'b0, 1'b1, "R3 past window");
        look(32'hFF00_0010, 2'd2, 1'b1, 8'd5, 1'b0, 1'b1, "R2 priv flat");
        look(32'h4000_1234, 2'd2, 1'b0, 8'd5, 1'b0, 1'b0, "R4 off low");
        look(32'hC000_0010, 2'd1, 1'b1, 8'd5, 1'b0, 1'b0, "R4 off high");
        look(32'h0034_5678, 2'd2, 1'b0, 8'd5, 1'b0, 1'b0, "R4 off no checks");
        look(32'hC000_0010, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R9 mapped upper miss");
        // Boundary wrap and slot reuse
        idle();
        repl_bound = 6'd20;
        for (int i = 0; i < 6; i++) look(32'h7FFF_F000, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R12 bound wrap");
        while (mctr != 1) look(32'h7FFF_F000, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R12 bound walk");
        put(32'h0001_2000, 32'h0600_0000, 2'd1, 8'd5, 2'b11, 1'b1, 1'b0, 1'b1);
        look(32'h0001_2ABC, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R13 slot replaced");
        look(32'h7FFF_F000, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R12 step");
        idle();
        repl_bound = 6'd1;
        look(32'h7FFF_F000, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R12 above bound");
        look(32'h7FFF_F000, 2'd1, 1'b1, 8'd5, 1'b0, 1'b1, "R12 after wrap");
        idle();
        repl_bound = 6'd0;
        for (int i = 0; i < 70; i++) look(32'h7FFF_F000, 2'd2, 1'b1, 8'd5, 1'b0, 1'b1, "R12 full wrap");
        idle();
        idle();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule